// File: doc/BRIEF.md
# System Bus Address Decoder

This block sits between a 32-bit CPU request port and a set of memory and peripheral regions. Each request carries an address, an access size (byte, halfword or word), a write enable and write data. The decoder first aligns the address to the access size. It then picks a region from the top address byte and works out the local offset inside that region. Each region has its own mirroring mask. The IO region has a single aliased register, and the video memory area is folded because its size is not a power of two. The decoder raises one select line and drives the offset on a shared bus. The size, write enable and write data pass through unchanged.

Some accesses reach no region and raise no select line. These are writes to the boot ROM, writes to the read-only cartridge windows, boot ROM reads at or above its limit, and any access to an unmapped page. Read data coming back from the regions goes through a one-hot multiplexer. It is registered by a two-state response machine. The state `RSP_IDLE` moves to `RSP_BUSY` when a read is accepted. `RSP_BUSY` stays in `RSP_BUSY` when another read arrives and returns to `RSP_IDLE` otherwise. While in `RSP_BUSY` the block presents one cycle of response valid with the captured data. A read that reaches no region returns zero.

Top module: `sys_bus_decoder`

## Requirements
- R1: Size encoding is 0 = byte, 1 = halfword, 2 = word, 3 = treated as word. Halfword accesses clear address bit 0 and word accesses clear bits 1:0 before any decoding. Byte accesses keep every bit.
- R2: Select bits are indexed 0 boot ROM, 1 external work RAM, 2 internal work RAM, 3 IO, 4 palette, 5 video RAM, 6 object attributes, 7 cartridge. At most one select bit is high. No select bit is high while `req_valid` is low. `bus_we`, `bus_size` and `bus_wdata` follow the request in the same cycle.
- R3: Page 0x02 selects external work RAM with offset equal to the aligned address AND 0x3FFFF. Page 0x03 selects internal work RAM with offset equal to the aligned address AND 0x7FFF.
- R4: Page 0x04 selects IO with offset equal to the aligned address AND 0x7FF. When the low 16 bits of the aligned address are 0x8000, the offset is 0x800 instead.
- R5: Page 0x05 selects palette RAM and page 0x07 selects object attribute memory. Both use offset = aligned address AND 0x3FF.
- R6: Page 0x06 selects video RAM. The offset is the aligned address AND 0x1FFFF, and 0x8000 is subtracted from it when it is greater than 0x18000. Exactly 0x18000 is not folded.
- R7: A page 0x00 read below 0x4000 selects boot ROM with offset equal to the aligned address. A read at or above 0x4000 selects nothing and returns zero. A write to page 0x00 selects nothing.
- R8: Pages 0x08 to 0x0F read as cartridge with offset equal to the aligned address. Writes select the cartridge only on pages 0x0D, 0x0E and 0x0F. Writes to pages 0x08 to 0x0C select nothing.
- R9: Every other page selects nothing. A read there returns zero.
- R10: Every valid read gives `rsp_valid` high in the next cycle, with `rsp_data` equal to the selected region's `rgn_rdata` lane as sampled in the request cycle. Writes and idle cycles give `rsp_valid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size code |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rgn_rdata | input | 256 | Read data from the regions, 32 bits per region, region 0 in the low lane |
| bus_sel | output | 8 | One-hot region select |
| bus_ofs | output | 32 | Local offset inside the selected region, zero when none is selected |
| bus_size | output | 2 | Forwarded access size |
| bus_we | output | 1 | Forwarded write enable, qualified by req_valid |
| bus_wdata | output | 32 | Forwarded write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Registered read data |

## Verification
The response for one read and the decode of the next request share the same cycle. In that cycle, `rsp_valid`/`rsp_data` belong to request N while `bus_sel`/`bus_ofs` already belong to request N+1. The bench provokes this by issuing requests back to back with no idle cycles, mixing reads, dropped writes and unmapped reads. It changes every region's read lane on each cycle, so data captured in the wrong cycle or from the wrong lane shows up as a mismatch. Each cycle, the reference model checks the decode of the current request and the response owed by the previous one.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

    localparam int NUM_RGN = 8;

    typedef enum logic [2:0] {
        RGN_BOOT  = 3'd0,
        RGN_EWRAM = 3'd1,
        RGN_IWRAM = 3'd2,
        RGN_IO    = 3'd3,
        RGN_PAL   = 3'd4,
        RGN_VRAM  = 3'd5,
        RGN_OAM   = 3'd6,
        RGN_CART  = 3'd7
    } rgn_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_BUSY = 1'b1
    } rsp_state_e;

    typedef struct packed {
        logic hit;
        rgn_e rgn;
    } route_t;

    // page codes (address bits 31:24)
    localparam logic [7:0] PG_BOOT   = 8'h00;
    localparam logic [7:0] PG_EWRAM  = 8'h02;
    localparam logic [7:0] PG_IWRAM  = 8'h03;
    localparam logic [7:0] PG_IO     = 8'h04;
    localparam logic [7:0] PG_PAL    = 8'h05;
    localparam logic [7:0] PG_VRAM   = 8'h06;
    localparam logic [7:0] PG_OAM    = 8'h07;
    localparam logic [7:0] PG_ROM0A  = 8'h08;
    localparam logic [7:0] PG_ROM0B  = 8'h09;
    localparam logic [7:0] PG_ROM1A  = 8'h0A;
    localparam logic [7:0] PG_ROM1B  = 8'h0B;
    localparam logic [7:0] PG_ROM2A  = 8'h0C;
    localparam logic [7:0] PG_ROM2B  = 8'h0D;
    localparam logic [7:0] PG_SAVEA  = 8'h0E;
    localparam logic [7:0] PG_SAVEB  = 8'h0F;

endpackage

// File: rtl/sbd_align.sv
module sbd_align
    import sbd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] aligned
);

    always_comb begin
        unique case (size_e'(size))
            SZ_BYTE: aligned = addr;
            SZ_HALF: aligned = {addr[ADDR_W-1:1], 1'b0};
            SZ_WORD,
            SZ_RSVD: aligned = {addr[ADDR_W-1:2], 2'b00};
            default: aligned = addr;
        endcase
    end

endmodule

// File: rtl/sbd_route.sv
module sbd_route
    import sbd_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] BOOT_LIMIT = 32'h0000_4000
) (
    input  logic              valid,
    input  logic              we,
    input  logic [ADDR_W-1:0] aligned,
    output route_t            route
);

    localparam int PAGE_LSB = ADDR_W - 8;

    logic [7:0] page;
    logic       hit_raw;
    rgn_e       rgn_raw;

    assign page = aligned[ADDR_W-1:PAGE_LSB];

    always_comb begin
        hit_raw = 1'b0;
        rgn_raw = RGN_BOOT;
        unique case (page)
            PG_BOOT: begin
                rgn_raw = RGN_BOOT;
                hit_raw = !we && (aligned < BOOT_LIMIT);
            end
            PG_EWRAM: begin
                rgn_raw = RGN_EWRAM;
                hit_raw = 1'b1;
            end
            PG_IWRAM: begin
                rgn_raw = RGN_IWRAM;
                hit_raw = 1'b1;
            end
            PG_IO: begin
                rgn_raw = RGN_IO;
                hit_raw = 1'b1;
            end
            PG_PAL: begin
                rgn_raw = RGN_PAL;
                hit_raw = 1'b1;
            end
            PG_VRAM: begin
                rgn_raw = RGN_VRAM;
                hit_raw = 1'b1;
            end
            PG_OAM: begin
                rgn_raw = RGN_OAM;
                hit_raw = 1'b1;
            end
            PG_ROM0A, PG_ROM0B, PG_ROM1A, PG_ROM1B, PG_ROM2A: begin
                rgn_raw = RGN_CART;
                hit_raw = !we;
            end
            PG_ROM2B, PG_SAVEA, PG_SAVEB: begin
                rgn_raw = RGN_CART;
                hit_raw = 1'b1;
            end
            default: begin
                rgn_raw = RGN_BOOT;
                hit_raw = 1'b0;
            end
        endcase
    end

    assign route.hit = valid && hit_raw;
    assign route.rgn = rgn_raw;

endmodule

// File: rtl/sbd_offset.sv
module sbd_offset
    import sbd_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                EWRAM_BITS = 18,
    parameter int                IWRAM_BITS = 15,
    parameter int                IO_BITS    = 11,
    parameter int                PAL_BITS   = 10,
    parameter int                OAM_BITS   = 10,
    parameter int                VRAM_BITS  = 17,
    parameter logic [ADDR_W-1:0] VRAM_LIMIT = 32'h0001_8000,
    parameter logic [ADDR_W-1:0] VRAM_SUB   = 32'h0000_8000,
    parameter logic [15:0]       IO_ALIAS_MATCH = 16'h8000,
    parameter logic [ADDR_W-1:0] IO_ALIAS_OFS   = 32'h0000_0800
) (
    input  route_t            route,
    input  logic [ADDR_W-1:0] aligned,
    output logic [ADDR_W-1:0] ofs
);

    logic [ADDR_W-1:0] ew_ofs;
    logic [ADDR_W-1:0] iw_ofs;
    logic [ADDR_W-1:0] io_ofs;
    logic [ADDR_W-1:0] pal_ofs;
    logic [ADDR_W-1:0] oam_ofs;
    logic [ADDR_W-1:0] vram_raw;
    logic [ADDR_W-1:0] vram_ofs;
    logic              io_alias;

    assign ew_ofs  = ADDR_W'(aligned[EWRAM_BITS-1:0]);
    assign iw_ofs  = ADDR_W'(aligned[IWRAM_BITS-1:0]);
    assign pal_ofs = ADDR_W'(aligned[PAL_BITS-1:0]);
    assign oam_ofs = ADDR_W'(aligned[OAM_BITS-1:0]);

    assign io_alias = (aligned[15:0] == IO_ALIAS_MATCH);
    assign io_ofs   = io_alias ? IO_ALIAS_OFS : ADDR_W'(aligned[IO_BITS-1:0]);

    assign vram_raw = ADDR_W'(aligned[VRAM_BITS-1:0]);
    assign vram_ofs = (vram_raw > VRAM_LIMIT) ? (vram_raw - VRAM_SUB) : vram_raw;

    always_comb begin
        ofs = '0;
        if (route.hit) begin
            unique case (route.rgn)
                RGN_BOOT:  ofs = aligned;
                RGN_EWRAM: ofs = ew_ofs;
                RGN_IWRAM: ofs = iw_ofs;
                RGN_IO:    ofs = io_ofs;
                RGN_PAL:   ofs = pal_ofs;
                RGN_VRAM:  ofs = vram_ofs;
                RGN_OAM:   ofs = oam_ofs;
                RGN_CART:  ofs = aligned;
                default:   ofs = '0;
            endcase
        end
    end

endmodule

// File: rtl/sbd_rdata_mux.sv
module sbd_rdata_mux #(
    parameter int NUM   = 8,
    parameter int WIDTH = 32
) (
    input  logic [NUM-1:0]       sel,
    input  logic [NUM*WIDTH-1:0] lanes,
    output logic [WIDTH-1:0]     dout
);

    logic [WIDTH-1:0] gated [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_lane
        assign gated[g] = sel[g] ? lanes[g*WIDTH +: WIDTH] : '0;
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < NUM; i++) begin
            dout = dout | gated[i];
        end
    end

endmodule

// File: rtl/sbd_resp_fsm.sv
module sbd_resp_fsm
    import sbd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_accept,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE: state_d = rd_accept ? RSP_BUSY : RSP_IDLE;
            RSP_BUSY: state_d = rd_accept ? RSP_BUSY : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_accept) begin
            data_q <= rd_word;
        end
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE: begin
                rsp_valid = 1'b0;
                rsp_data  = '0;
            end
            RSP_BUSY: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_data  = '0;
            end
        endcase
    end

endmodule

// File: rtl/sys_bus_decoder.sv
module sys_bus_decoder
    import sbd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int VRAM_BITS = 17
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [1:0]                req_size,
    input  logic                      req_we,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic [NUM_RGN*DATA_W-1:0] rgn_rdata,
    output logic [NUM_RGN-1:0]        bus_sel,
    output logic [ADDR_W-1:0]         bus_ofs,
    output logic [1:0]                bus_size,
    output logic                      bus_we,
    output logic [DATA_W-1:0]         bus_wdata,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_data
);

    logic [ADDR_W-1:0] aligned;
    route_t            route;
    logic [DATA_W-1:0] mux_word;
    logic              rd_accept;

    sbd_align #(.ADDR_W(ADDR_W)) u_align (
        .addr    (req_addr),
        .size    (req_size),
        .aligned (aligned)
    );

    sbd_route #(.ADDR_W(ADDR_W)) u_route (
        .valid   (req_valid),
        .we      (req_we),
        .aligned (aligned),
        .route   (route)
    );

    sbd_offset #(.ADDR_W(ADDR_W), .VRAM_BITS(VRAM_BITS)) u_offset (
        .route   (route),
        .aligned (aligned),
        .ofs     (bus_ofs)
    );

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_sel
        assign bus_sel[g] = route.hit && (route.rgn == rgn_e'(g));
    end

    sbd_rdata_mux #(.NUM(NUM_RGN), .WIDTH(DATA_W)) u_mux (
        .sel   (bus_sel),
        .lanes (rgn_rdata),
        .dout  (mux_word)
    );

    assign rd_accept = req_valid && !req_we;

    sbd_resp_fsm #(.DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_accept (rd_accept),
        .rd_word   (mux_word),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign bus_size  = req_size;
    assign bus_we    = req_valid && req_we;
    assign bus_wdata = req_wdata;

endmodule

// File: rtl/sbd_checker.sv
module sbd_checker
    import sbd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [31:0]         req_addr,
    input logic                req_we,
    input logic [NUM_RGN-1:0]  bus_sel,
    input logic [31:0]         bus_ofs,
    input logic                rsp_valid,
    input logic [31:0]         rsp_data
);

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_sel));

    // R2
    idle_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (bus_sel == '0));

    // R7
    boot_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel[RGN_BOOT] |-> (!req_we && (req_addr < 32'h0000_4000)));

    // R8
    cart_write_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel[RGN_CART] && req_we) |-> (req_addr >= 32'h0D00_0000));

    // R6
    vram_fold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel[RGN_VRAM] |-> (bus_ofs <= 32'h0001_8000));

    // R10
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we) |=> rsp_valid);

    // R10
    no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_we) |=> !rsp_valid);

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we && (bus_sel == '0)) |=> (rsp_data == '0));

endmodule

bind sys_bus_decoder sbd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_we    (req_we),
    .bus_sel   (bus_sel),
    .bus_ofs   (bus_ofs),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/sys_bus_decoder_bench.sv
module sys_bus_decoder_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [1:0]   req_size = '0;
    logic         req_we = 1'b0;
    logic [31:0]  req_wdata = '0;
    logic [255:0] rgn_rdata = '0;
    logic [7:0]   bus_sel;
    logic [31:0]  bus_ofs;
    logic [1:0]   bus_size;
    logic         bus_we;
    logic [31:0]  bus_wdata;
    logic         rsp_valid;
    logic [31:0]  rsp_data;

    int total = 0;
    int bad = 0;
    int seq = 0;
    logic [31:0] resp_q[$];
    string       resp_tag_q[$];

    always #2 clk = ~clk;

    sys_bus_decoder u_sys_bus_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_we(req_we), .req_wdata(req_wdata),
        .rgn_rdata(rgn_rdata), .bus_sel(bus_sel), .bus_ofs(bus_ofs),
        .bus_size(bus_size), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic void ref_map(input logic [31:0] addr, input int sz, input bit we,
                                    output int idx, output logic [31:0] ofs, output string tag);
        logic [31:0] a;
        int pg;
        a = addr;
        if (sz == 1) a[0] = 1'b0;
        else if (sz >= 2) a[1:0] = 2'b00;
        pg = int'(a[31:24]);
        idx = -1;
        ofs = '0;
        tag = "R9";
        if (pg == 0) begin
            tag = "R7";
            if (!we && a < 32'h4000) begin idx = 0; ofs = a; end
        end else if (pg == 2) begin
            tag = "R3"; idx = 1; ofs = a & 32'h3FFFF;
        end else if (pg == 3) begin
            tag = "R3"; idx = 2; ofs = a & 32'h7FFF;
        end else if (pg == 4) begin
            tag = "R4"; idx = 3;
            ofs = (a[15:0] == 16'h8000) ? 32'h800 : (a & 32'h7FF);
        end else if (pg == 5) begin
            tag = "R5"; idx = 4; ofs = a & 32'h3FF;
        end else if (pg == 6) begin
            tag = "R6"; idx = 5; ofs = a & 32'h1FFFF;
            if (ofs > 32'h18000) ofs = ofs - 32'h8000;
        end else if (pg == 7) begin
            tag = "R5"; idx = 6; ofs = a & 32'h3FF;
        end else if (pg >= 8 && pg <= 12) begin
            tag = "R8";
            if (!we) begin idx = 7; ofs = a; end
        end else if (pg >= 13 && pg <= 15) begin
            tag = "R8"; idx = 7; ofs = a;
        end
        if (a != addr) tag = {tag, "/R1"};
    endfunction

    // One clock of stimulus: check the response owed by the previous cycle,
    // drive the new request, then check its decode.
    task automatic issue(input bit v, input logic [31:0] addr, input int sz, input bit we);
        int idx;
        logic [31:0] ofs;
        logic [7:0]  exp_sel;
        string tag;
        @(negedge clk);
        if (resp_q.size() > 0) begin
            logic [31:0] ed;
            string et;
            ed = resp_q.pop_front();
            et = resp_tag_q.pop_front();
            chk(rsp_valid === 1'b1, "R10 rsp_valid", 32'(rsp_valid), 32'd1);
            chk(rsp_data === ed, et, rsp_data, ed);
        end else begin
            chk(rsp_valid === 1'b0, "R10 no response", 32'(rsp_valid), 32'd0);
        end
        seq++;
        req_valid = v;
        req_addr  = addr;
        req_size  = 2'(sz);
        req_we    = we;
        req_wdata = 32'h5A00_0000 ^ 32'(seq);
        for (int i = 0; i < 8; i++) begin
            rgn_rdata[i*32 +: 32] = {4'hA, 4'(i), 24'(seq * 7 + i)};
        end
        #1;
        if (v) begin
            ref_map(addr, sz, we, idx, ofs, tag);
        end else begin
            idx = -1; ofs = '0; tag = "R2 idle";
        end
        exp_sel = (idx >= 0) ? (8'd1 << idx) : 8'd0;
        chk(bus_sel === exp_sel, tag, 32'(bus_sel), 32'(exp_sel));
        if (idx >= 0) chk(bus_ofs === ofs, tag, bus_ofs, ofs);
        if (v) begin
            chk(bus_we === we && bus_size === 2'(sz) && bus_wdata === req_wdata,
                "R2 forward", {bus_wdata[29:0], bus_we, 1'b0}, {req_wdata[29:0], we, 1'b0});
        end
        if (v && !we) begin
            resp_q.push_back(idx >= 0 ? rgn_rdata[idx*32 +: 32] : 32'h0);
            resp_tag_q.push_back(idx >= 0 ? "R10 data" : {tag, " zero"});
        end
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state: R2, R10
        chk(rsp_valid === 1'b0, "R10 reset", 32'(rsp_valid), 32'd0);
        chk(bus_sel === 8'd0, "R2 reset", 32'(bus_sel), 32'd0);
        rst_n = 1'b1;
        issue(0, 32'h0200_0000, 2, 0);
        // R1 alignment
        issue(1, 32'h0200_0003, 2, 0);
        issue(1, 32'h0200_0003, 1, 0);
        issue(1, 32'h0200_0003, 0, 0);
        issue(1, 32'h0200_0003, 3, 0);
        // R3
        issue(1, 32'h02FC_0004, 2, 0);
        issue(1, 32'h0300_FFFC, 2, 0);
        issue(1, 32'h0312_3456, 0, 1);
        // R4
        issue(1, 32'h0400_8000, 2, 0);
        issue(1, 32'h04FF_8001, 1, 0);
        issue(1, 32'h0400_8001, 0, 0);
        issue(1, 32'h0400_1234, 1, 1);
        issue(1, 32'h0400_8002, 2, 1);
        // R5
        issue(1, 32'h0500_0BFE, 1, 0);
        issue(1, 32'h07FF_FFFF, 0, 1);
        // R6
        issue(1, 32'h0601_8000, 2, 0);
        issue(1, 32'h0601_8004, 2, 0);
        issue(1, 32'h0601_8001, 0, 1);
        issue(1, 32'h0601_FFFC, 2, 0);
        issue(1, 32'h0602_0010, 2, 0);
        // R7
        issue(1, 32'h0000_3FFC, 2, 0);
        issue(1, 32'h0000_3FFF, 0, 0);
        issue(1, 32'h0000_4000, 2, 0);
        issue(1, 32'h0000_0010, 2, 1);
        // R8
        issue(1, 32'h0800_0100, 2, 0);
        issue(1, 32'h0C00_0000, 1, 0);
        issue(1, 32'h0800_0100, 2, 1);
        issue(1, 32'h0CFF_FFFC, 2, 1);
        issue(1, 32'h0D00_0000, 2, 1);
        issue(1, 32'h0E00_1234, 0, 1);
        issue(1, 32'h0F00_0002, 1, 0);
        // R9
        issue(1, 32'h0100_0000, 2, 0);
        issue(1, 32'h1000_0000, 2, 0);
        issue(1, 32'hFF00_0000, 0, 0);
        issue(1, 32'h2000_0020, 2, 1);
        issue(0, 32'h0200_0000, 2, 0);
        // back-to-back mixed traffic, R10 overlap
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            a = $urandom;
            a[31:24] = 8'($urandom_range(0, 17));
            if ((n % 5) == 0) a[31:24] = 8'h06;
            issue(($urandom_range(0, 7) != 0), a, $urandom_range(0, 3), $urandom_range(0, 1) == 1);
        end
        issue(0, 32'h0, 0, 0);
        issue(0, 32'h0, 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule